// File: doc/BRIEF.md
# Asynchronous Tick Counter with CPU-Domain Readback

The block is an up-counter that is clocked by a slow, free-running timer clock. It has no fixed phase relation to the fast CPU clock. The count advances by one on every rising edge of the timer clock and wraps from its maximum value to zero. On each timer edge the new count is also placed in a holding register. The CPU domain copies that holding register into its own readback register once a toggle, carried across two synchronizer flops, reports that the edge has occurred. The readback is therefore a snapshot that refreshes only on timer edges. After the CPU clock has been stopped and restarted, the snapshot keeps its old value until a timer edge is seen through the synchronizer.

Two events come from the timer domain: a wrap and a compare match. A compare match occurs when the count equals a compare value. Each event flips a toggle bit in the timer domain. The CPU domain synchronizes that bit, detects its edge and sets a sticky flag. Software clears a flag by writing a one to it. An interrupt request is raised for any flag whose enable is set.

The compare output pin toggles on every match, directly on the timer clock. A wake request for a sleeping CPU is also produced on the timer clock, so it works while the CPU clock is off.

Top module: `async_tick_counter`

## Requirements
- R1: While rstN is low, readCount, flags, irq, wakeReq and ocPin are all zero.
- R2: The count starts at 0 after reset and increments on every rising tmrClk edge, wrapping from 2^CNT_W-1 to 0. Each time readCount changes, it equals the count produced by the most recent tmrClk edge.
- R3: readCount changes only when a tmrClk edge is delivered through the synchronizer. When cpuClk restarts after a stop, readCount still holds the value it had before the stop after the first cpuClk rising edge.
- R4: Flag bit 0 (overflow) is set when the count wraps from its maximum to 0.
- R5: With SYNC_STAGES=2, a flag becomes visible after the third cpuClk rising edge that follows the tmrClk edge carrying the event. It is not visible after the second.
- R6: Flags are sticky. A flag bit clears only in a cpuClk cycle where the matching flagClr bit is 1. Bit 0 is overflow and bit 1 is compare.
- R7: irq is 1 exactly when some flag bit is set together with its enable: ovfIntEn for bit 0, cmpIntEn for bit 1.
- R8: A match is a tmrClk cycle in which the count equals cmpValue. The tmrClk edge that ends that cycle toggles ocPin and sets flag bit 1. At all other edges ocPin holds its value.
- R9: ocPin changes at the tmrClk edge itself, before any cpuClk edge has occurred.
- R10: After a tmrClk cycle holding an enabled overflow or match condition, wakeReq is 1 for exactly the following tmrClk cycle. A disabled condition does not raise wakeReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmrClk | input | 1 | Slow asynchronous timer clock |
| cpuClk | input | 1 | Fast CPU clock, may be stopped |
| rstN | input | 1 | Power-up reset, active low, for both domains |
| cmpValue | input | CNT_W | Compare value, held static while counting |
| ovfIntEn | input | 1 | Interrupt and wake enable for overflow |
| cmpIntEn | input | 1 | Interrupt and wake enable for compare match |
| flagClr | input | 2 | Write-one-to-clear strobes for flag bits |
| readCount | output | CNT_W | CPU-domain snapshot of the count |
| flags | output | 2 | Sticky event flags, bit 0 overflow, bit 1 compare |
| irq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Timer-domain wake request |
| ocPin | output | 1 | Compare output pin |

## Verification
The bench uses the default CNT_W=8 and SYNC_STAGES=2, with the timer clock ten times slower than the CPU clock. Its edges are placed so that they never coincide with CPU edges. With 8 bits, a full wrap takes 256 timer cycles, so the overflow flag and the overflow wake request are reached in a short run. With two synchronizer stages, the latency is exactly three CPU edges, so the bench can sample both sides of the cycle in which a flag appears. Stopping the CPU clock across an odd number of timer edges makes the stale readback visible when the clock restarts.

// File: rtl/atc_pkg.sv
package atc_pkg;
  // toggle bits handed from the timer domain to the CPU domain
  typedef struct packed {
    logic tick;
    logic ovf;
    logic cmp;
  } evtTog_t;

  localparam int EVT_BITS = 3;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;
  localparam int FLAG_BITS = 2;
endpackage

// File: rtl/atc_sync.sv
module atc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/atc_timer_dp.sv
module atc_timer_dp import atc_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             tmrClk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic             ovfEn,
  input  logic             cmpEn,
  output logic [CNT_W-1:0] cntNow,
  output logic [CNT_W-1:0] cntHold,
  output evtTog_t          togs,
  output logic             ocPin,
  output logic             wakeReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ;
  logic ovfHit, cmpHit;

  assign ovfHit = (cntQ == CNT_MAX);
  assign cmpHit = (cntQ == cmpValue);

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      cntHold <= '0;
      togs    <= '0;
      ocPin   <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      cntQ      <= cntQ + 1'b1;
      cntHold   <= cntQ + 1'b1;
      togs.tick <= ~togs.tick;
      if (ovfHit) togs.ovf <= ~togs.ovf;
      if (cmpHit) begin
        togs.cmp <= ~togs.cmp;
        ocPin    <= ~ocPin;
      end
      wakeReq <= (ovfHit & ovfEn) | (cmpHit & cmpEn);
    end
  end

  assign cntNow = cntQ;
endmodule

// File: rtl/atc_cpu_ctrl.sv
module atc_cpu_ctrl import atc_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 cpuClk,
  input  logic                 rstN,
  input  evtTog_t              togs,
  input  logic [CNT_W-1:0]     cntHold,
  input  logic [FLAG_BITS-1:0] flagClr,
  input  logic                 ovfEn,
  input  logic                 cmpEn,
  output logic [CNT_W-1:0]     readCount,
  output logic [FLAG_BITS-1:0] flags,
  output logic                 irq
);
  evtTog_t togSync, togPrev, evtEdge;
  logic [FLAG_BITS-1:0] setVec, enVec;

  atc_sync #(.STAGES(SYNC_STAGES), .WIDTH(EVT_BITS)) uSync (
    .clk(cpuClk), .rstN(rstN), .asyncIn(togs), .syncOut(togSync)
  );

  assign evtEdge = togSync ^ togPrev;

  always_comb begin
    setVec = '0;
    setVec[FLAG_OVF] = evtEdge.ovf;
    setVec[FLAG_CMP] = evtEdge.cmp;
    enVec = '0;
    enVec[FLAG_OVF] = ovfEn;
    enVec[FLAG_CMP] = cmpEn;
  end

  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      togPrev   <= '0;
      readCount <= '0;
      flags     <= '0;
    end else begin
      togPrev <= togSync;
      if (evtEdge.tick) readCount <= cntHold;
      flags <= (flags & ~flagClr) | setVec;
    end
  end

  assign irq = |(flags & enVec);
endmodule

// File: rtl/async_tick_counter.sv
module async_tick_counter import atc_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tmrClk,
  input  logic             cpuClk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cmpValue,
  input  logic             ovfIntEn,
  input  logic             cmpIntEn,
  input  logic [1:0]       flagClr,
  output logic [CNT_W-1:0] readCount,
  output logic [1:0]       flags,
  output logic             irq,
  output logic             wakeReq,
  output logic             ocPin
);
  evtTog_t          togs;
  logic [CNT_W-1:0] cntHold;
  logic [CNT_W-1:0] cntNow;

  atc_timer_dp #(.CNT_W(CNT_W)) uDp (
    .tmrClk(tmrClk), .rstN(rstN), .cmpValue(cmpValue),
    .ovfEn(ovfIntEn), .cmpEn(cmpIntEn),
    .cntNow(cntNow), .cntHold(cntHold), .togs(togs),
    .ocPin(ocPin), .wakeReq(wakeReq)
  );

  atc_cpu_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .cpuClk(cpuClk), .rstN(rstN), .togs(togs), .cntHold(cntHold),
    .flagClr(flagClr), .ovfEn(ovfIntEn), .cmpEn(cmpIntEn),
    .readCount(readCount), .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
  parameter int CNT_W = 8
) (
  input logic             tmrClk,
  input logic             cpuClk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpValue,
  input logic             ovfIntEn,
  input logic             cmpIntEn,
  input logic             ocPin,
  input logic             wakeReq,
  input logic [1:0]       flags,
  input logic [1:0]       flagClr,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_COUNT_STEP: assert property (@(posedge tmrClk) disable iff (!rstN)
    $past(rstN) |-> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

  AST_OC_ONLY_ON_MATCH: assert property (@(posedge tmrClk) disable iff (!rstN)
    (ocPin != $past(ocPin)) |-> ($past(cnt) == $past(cmpValue))); // R8

  AST_WAKE_HAS_CAUSE: assert property (@(posedge tmrClk) disable iff (!rstN)
    wakeReq |-> (($past(cnt) == $past(cmpValue) && $past(cmpIntEn)) ||
                 ($past(cnt) == CNT_MAX && $past(ovfIntEn)))); // R10

  AST_FLAG_STICKY: assert property (@(posedge cpuClk) disable iff (!rstN)
    $past(rstN) |-> ((($past(flags) & ~$past(flagClr)) & ~flags) == 2'b00)); // R6

  AST_NO_IRQ_WITHOUT_FLAG: assert property (@(posedge cpuClk) disable iff (!rstN)
    (flags == 2'b00) |-> !irq); // R7
endmodule

bind async_tick_counter atc_checker #(.CNT_W(CNT_W)) uChk (
  .tmrClk(tmrClk), .cpuClk(cpuClk), .rstN(rstN), .cnt(cntNow),
  .cmpValue(cmpValue), .ovfIntEn(ovfIntEn), .cmpIntEn(cmpIntEn),
  .ocPin(ocPin), .wakeReq(wakeReq), .flags(flags), .flagClr(flagClr),
  .irq(irq)
);

// File: tb/async_tick_counter_test.sv
`timescale 1ns/1ps
module async_tick_counter_test;
  localparam int CPU_HALF = 5;
  localparam int TMR_HALF = 50;
  localparam int CNT_W = 8;
  localparam int CNT_MOD = 1 << CNT_W;
  localparam int CMP_AT = 100;

  logic tmrClk = 1'b0, cpuClk = 1'b0, rstN = 1'b0, cpuRun = 1'b1;
  logic [CNT_W-1:0] cmpValue = CMP_AT[CNT_W-1:0];
  logic ovfIntEn = 1'b0, cmpIntEn = 1'b1;
  logic [1:0] flagClr = 2'b00;
  logic [CNT_W-1:0] readCount;
  logic [1:0] flags;
  logic irq, wakeReq, ocPin;

  int nChk = 0, nFail = 0;
  int modelCnt = 0;
  int expQ[$];
  int lastRead = 0;
  int savedRead;
  bit done = 0;

  async_tick_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
    .tmrClk(tmrClk), .cpuClk(cpuClk), .rstN(rstN), .cmpValue(cmpValue),
    .ovfIntEn(ovfIntEn), .cmpIntEn(cmpIntEn), .flagClr(flagClr),
    .readCount(readCount), .flags(flags), .irq(irq),
    .wakeReq(wakeReq), .ocPin(ocPin)
  );

  initial forever begin #CPU_HALF; if (cpuRun) cpuClk = ~cpuClk; end
  initial forever #TMR_HALF tmrClk = ~tmrClk;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pushExp(input int v);
    expQ.push_back(v);
  endtask

  // driver: the expected count after each timer edge
  always @(posedge tmrClk or negedge rstN) begin
    if (!rstN) modelCnt <= 0;
    else begin
      pushExp((modelCnt + 1) % CNT_MOD);
      modelCnt <= (modelCnt + 1) % CNT_MOD;
    end
  end

  // monitor: every readback change must show the newest expected count
  always @(negedge cpuClk) begin
    if (rstN && int'(readCount) != lastRead) begin
      if (expQ.size() == 0) chk("R2 readback without timer edge", int'(readCount), lastRead);
      else chk("R2 readback value", int'(readCount), expQ[$]);
      expQ.delete();
      lastRead = int'(readCount);
    end
  end

  initial begin
    #120;
    chk("R1 reset readCount", int'(readCount), 0);
    chk("R1 reset flags", int'(flags), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset wakeReq", int'(wakeReq), 0);
    chk("R1 reset ocPin", int'(ocPin), 0);
    #110 rstN = 1'b1;

    // compare match at count CMP_AT, compare enabled
    wait (modelCnt == CMP_AT);
    @(posedge tmrClk);
    #2;
    chk("R9 ocPin toggles at timer edge", int'(ocPin), 1);
    chk("R10 wakeReq after enabled match", int'(wakeReq), 1);
    chk("R5 compare flag not yet", int'(flags[1]), 0);
    #18;
    chk("R5 compare flag after two cpu edges", int'(flags[1]), 0);
    #10;
    chk("R5 compare flag after three cpu edges", int'(flags[1]), 1);
    chk("R8 compare flag set", int'(flags[1]), 1);
    chk("R7 irq with compare enabled", int'(irq), 1);
    #72;
    chk("R10 wakeReq lasts one timer cycle", int'(wakeReq), 0);
    chk("R8 ocPin holds without match", int'(ocPin), 1);
    repeat (3) @(posedge tmrClk);
    @(negedge cpuClk);
    chk("R6 compare flag sticky", int'(flags[1]), 1);
    chk("R6 overflow flag still clear", int'(flags[0]), 0);
    flagClr = 2'b01;
    @(negedge cpuClk);
    flagClr = 2'b00;
    chk("R6 clearing bit0 leaves bit1", int'(flags[1]), 1);
    flagClr = 2'b10;
    @(negedge cpuClk);
    flagClr = 2'b00;
    chk("R6 compare flag cleared", int'(flags[1]), 0);
    chk("R7 irq drops with flag", int'(irq), 0);

    // overflow with its enable off
    wait (modelCnt == CNT_MOD - 1);
    @(posedge tmrClk);
    #2;
    chk("R10 no wake when overflow disabled", int'(wakeReq), 0);
    chk("R8 ocPin holds at wrap", int'(ocPin), 1);
    #28;
    chk("R4 overflow flag set at wrap", int'(flags[0]), 1);
    chk("R2 count wrapped to zero", int'(readCount), 0);
    chk("R7 irq masked when overflow disabled", int'(irq), 0);
    @(negedge cpuClk);
    ovfIntEn = 1'b1;
    #1;
    chk("R7 irq once overflow enabled", int'(irq), 1);
    @(negedge cpuClk);
    flagClr = 2'b01;
    @(negedge cpuClk);
    flagClr = 2'b00;
    chk("R6 overflow flag cleared", int'(flags[0]), 0);
    chk("R7 irq after clear", int'(irq), 0);

    // stop the CPU clock across three timer edges
    @(posedge tmrClk);
    #40;
    @(negedge cpuClk);
    savedRead = int'(readCount);
    cpuRun = 1'b0;
    repeat (3) @(posedge tmrClk);
    #10 cpuRun = 1'b1;
    @(posedge cpuClk);
    @(negedge cpuClk);
    chk("R3 stale readback after restart", int'(readCount), savedRead);
    repeat (4) @(negedge cpuClk);
    chk("R3 readback refreshed after restart", int'(readCount), modelCnt);

    repeat (20) @(posedge tmrClk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end
endmodule